// File: doc/BRIEF.md
# Four-Channel DMA Start and Bus-Ownership Arbiter

This block decides when each of four DMA channels may begin moving data and which channel owns the transfer engine in any cycle. Each channel has a start condition chosen by a two-bit mode: immediate, horizontal-blank, vertical-blank or special-request. When its start condition fires, the channel loads a pending unit count from its programmed block length and waits a fixed start latency before it is allowed to compete for the bus. The memory datapath outside the block performs one unit transfer per `unit_done` pulse on behalf of the channel named by `grant_id`.

The grant always goes to the lowest-numbered channel that is enabled, has pending units and has finished its start latency. The grant is evaluated again after every unit, so a lower-numbered channel that becomes ready in the middle of another channel's block takes over at the next unit boundary. When the last unit of a block completes, the channel may disable itself, may ask the datapath to restore its destination pointer, and may raise a completion interrupt. A stall signal tells the CPU to hold off while any channel still has work.

Top module: `dma_trig_arb`

## Requirements
- R1: After reset no channel is enabled, `grant_valid`, `cpu_stall`, `irq` and `dst_restore` are all low.
- R2: The mode of channel i is `trig_mode[2i+1:2i]`, with 0 meaning immediate. An `en_set[i]` pulse on a disabled immediate-mode channel enables it and loads its pending count from `blk_count[CW*i +: CW]`, where a value of zero means 2^CW units; the channel is first granted in the cycle after the third rising clock edge following the pulse.
- R3: Mode 1 answers `hblank` and mode 2 answers `vblank`. A pulse arms every enabled channel of the matching mode whose pending count is zero, loading its count and granting it after the same three-edge latency; a pulse on a channel of another mode or one that still has pending units changes nothing.
- R4: Mode 3 arms a channel from its own `spec_req` bit only on channels 1 and 2; on channels 0 and 3 the request is discarded and the channel stays enabled but never granted.
- R5: `grant_id` names the lowest-indexed channel that is enabled, has nonzero pending units and has completed its start latency; a lower channel becoming ready takes the grant from a higher one at the next unit boundary.
- R6: Each `unit_done` pulse while `grant_valid` is high consumes one pending unit of the granted channel; a block therefore lasts exactly its programmed number of units.
- R7: When a block's last unit completes, the channel is disabled unless its `repeat_en` bit is set; an immediate-mode channel is disabled regardless of `repeat_en`. `ch_enabled` shows the enable state.
- R8: One cycle after a block's last unit, `dst_restore[i]` pulses for one cycle if `reload_en[i]` is set.
- R9: One cycle after a block's last unit, `irq[i]` pulses for one cycle if `irq_en[i]` is set.
- R10: `cpu_stall` is high exactly when at least one enabled channel has pending units, including during its start latency.
- R11: An `en_set` pulse on a channel that is already enabled has no effect: neither its pending count nor its start latency is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_set | input | NCH | Per-channel enable request pulse |
| trig_mode | input | 2*NCH | Per-channel start mode (0 immediate, 1 hblank, 2 vblank, 3 special) |
| repeat_en | input | NCH | Per-channel stay-enabled-after-block |
| irq_en | input | NCH | Per-channel completion interrupt enable |
| reload_en | input | NCH | Per-channel destination restore at block end |
| blk_count | input | CW*NCH | Per-channel block length in units, zero meaning 2^CW |
| hblank | input | 1 | Horizontal-blank pulse |
| vblank | input | 1 | Vertical-blank pulse |
| spec_req | input | NCH | Per-channel special start request |
| unit_done | input | 1 | One unit transfer of the granted channel has finished |
| grant_valid | output | 1 | Some channel owns the transfer engine |
| grant_id | output | IDW | Index of the owning channel |
| cpu_stall | output | 1 | CPU must hold off |
| ch_enabled | output | NCH | Current enable state of each channel |
| irq | output | NCH | Completion interrupt pulses |
| dst_restore | output | NCH | Destination-restore pulses |

## Verification
Directed sequences isolate single behaviours: a lone immediate channel measures the start latency and end-of-block pulses, a zero length separates the wrap-to-maximum rule from a plain count, and a blank pulse landing mid-block on a lower channel separates per-unit preemption from block-granular arbitration. Mismatched blank pulses, re-enables of a busy channel and special requests on all four channels tell ignored stimulus from reloads. A long stretch of random enables, blank pulses, special requests and sparse `unit_done` is then compared every cycle against a behavioural model, which exposes ordering corner cases such as a block ending in the same cycle a blank pulse arrives.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    TM_IMM = 2'd0,
    TM_HBL = 2'd1,
    TM_VBL = 2'd2,
    TM_SPC = 2'd3
  } trig_mode_e;

  // Does an external event start a block for a channel in this mode?
  function automatic logic trig_hit(input trig_mode_e m, input logic hb, input logic vb,
                                    input logic sp, input logic sp_ok);
    case (m)
      TM_HBL:  return hb;
      TM_VBL:  return vb;
      TM_SPC:  return sp & sp_ok;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dma_arb_chan.sv
module dma_arb_chan
  import dma_arb_pkg::*;
#(
  parameter int CW  = 16,
  parameter int LAT = 3,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          rpt,
  input  logic          irq_on,
  input  logic          reload_on,
  input  logic [CW-1:0] count,
  input  logic          en_set,
  input  logic          hb,
  input  logic          vb,
  input  logic          sp_req,
  input  logic          unit_ack,
  output logic          enabled,
  output logic          eligible,
  output logic          busy,
  output logic          irq_p,
  output logic          dst_p
);
  localparam int LW = $clog2(LAT + 1);
  localparam logic SPC_OK = (IDX == 1) || (IDX == 2);

  // zero length stands for the largest block
  function automatic logic [CW:0] units_of(input logic [CW-1:0] c);
    return (c == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, c};
  endfunction

  logic          en_q;
  logic [CW:0]   pend_q;
  logic [LW-1:0] wait_q;

  trig_mode_e mode_e;
  logic       start_imm, arm_evt, blk_end, keep_en, first_en;

  assign mode_e    = trig_mode_e'(mode);
  assign first_en  = en_set & ~en_q;
  assign start_imm = first_en & (mode_e == TM_IMM);
  assign arm_evt   = en_q & (pend_q == '0) & trig_hit(mode_e, hb, vb, sp_req, SPC_OK);
  assign blk_end   = unit_ack & (pend_q == {{CW{1'b0}}, 1'b1});
  assign keep_en   = rpt & (mode_e != TM_IMM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= '0;
      wait_q <= '0;
      irq_p  <= 1'b0;
      dst_p  <= 1'b0;
    end else begin
      irq_p <= blk_end & irq_on;
      dst_p <= blk_end & reload_on;
      if (start_imm || arm_evt) begin
        pend_q <= units_of(count);
        wait_q <= LW'(LAT);
      end else begin
        if (wait_q != '0) wait_q <= wait_q - 1'b1;
        if (unit_ack) pend_q <= pend_q - 1'b1;
      end
      if (first_en) en_q <= 1'b1;
      else if (blk_end && !keep_en) en_q <= 1'b0;
    end
  end

  assign enabled  = en_q;
  assign busy     = en_q & (pend_q != '0);
  assign eligible = busy & (wait_q == '0);

  // R2: a freshly started channel is held off by the start latency
  a_r2_start_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    start_imm |=> !eligible);
  // R3 / R11: a pending block is not reloaded by any start event
  a_r3_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !unit_ack) |=> (pend_q == $past(pend_q)));
  // R6: each granted unit consumes exactly one pending unit
  a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_ack && pend_q > 1) |=> (pend_q == $past(pend_q) - 1'b1));
  // R7: a non-repeating block end leaves the channel disabled
  a_r7_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && !keep_en) |=> !en_q);
  // R8: restore pulse only follows a block end with reload set
  a_r8_restore_cause: assert property (@(posedge clk) disable iff (!rst_n)
    dst_p |-> ($past(blk_end) && $past(reload_on)));
  // R9: interrupt pulse only follows a block end with interrupt set
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_p |-> ($past(blk_end) && $past(irq_on)));

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NCH = 4,
  parameter int IDW = 2
) (
  input  logic [NCH-1:0] req,
  output logic           valid,
  output logic [IDW-1:0] id
);
  always_comb begin
    valid = 1'b0;
    id    = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        id    = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_trig_arb.sv
module dma_trig_arb #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int LAT = 3,
  localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    en_set,
  input  logic [2*NCH-1:0]  trig_mode,
  input  logic [NCH-1:0]    repeat_en,
  input  logic [NCH-1:0]    irq_en,
  input  logic [NCH-1:0]    reload_en,
  input  logic [CW*NCH-1:0] blk_count,
  input  logic              hblank,
  input  logic              vblank,
  input  logic [NCH-1:0]    spec_req,
  input  logic              unit_done,
  output logic              grant_valid,
  output logic [IDW-1:0]    grant_id,
  output logic              cpu_stall,
  output logic [NCH-1:0]    ch_enabled,
  output logic [NCH-1:0]    irq,
  output logic [NCH-1:0]    dst_restore
);
  logic [NCH-1:0] eligible, busy, unit_ack;

  dma_arb_pick #(.NCH(NCH), .IDW(IDW)) u_pick (
    .req   (eligible),
    .valid (grant_valid),
    .id    (grant_id)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign unit_ack[g] = unit_done & grant_valid & (grant_id == IDW'(g));

    dma_arb_chan #(.CW(CW), .LAT(LAT), .IDX(g)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (trig_mode[2*g +: 2]),
      .rpt       (repeat_en[g]),
      .irq_on    (irq_en[g]),
      .reload_on (reload_en[g]),
      .count     (blk_count[CW*g +: CW]),
      .en_set    (en_set[g]),
      .hb        (hblank),
      .vb        (vblank),
      .sp_req    (spec_req[g]),
      .unit_ack  (unit_ack[g]),
      .enabled   (ch_enabled[g]),
      .eligible  (eligible[g]),
      .busy      (busy[g]),
      .irq_p     (irq[g]),
      .dst_p     (dst_restore[g])
    );
  end

  assign cpu_stall = |busy;

  // R5: the grant names a ready channel and no lower one is ready
  a_r5_lowest_ready: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (eligible[grant_id] &&
      ((eligible & ((NCH'(1) << grant_id) - NCH'(1))) == '0)));
  // R5: a ready channel always produces a grant
  a_r5_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|eligible) |-> grant_valid);
  // R10: the CPU is held whenever a channel owns the engine
  a_r10_stall_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> cpu_stall);
  // R6: at most one channel consumes a unit per cycle
  a_r6_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_ack));

endmodule

// File: tb/tb_dma_trig_arb.sv
module tb_dma_trig_arb;
  localparam int NCH = 4;
  localparam int CW  = 4;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] en_set = '0, repeat_en = '0, irq_en = '0, reload_en = '0, spec_req = '0;
  logic [2*NCH-1:0] trig_mode = '0;
  logic [CW*NCH-1:0] blk_count = '0;
  logic hblank = 0, vblank = 0, unit_done = 0;
  logic grant_valid, cpu_stall;
  logic [1:0] grant_id;
  logic [NCH-1:0] ch_enabled, irq, dst_restore;

  always #5 clk = ~clk;

  dma_trig_arb #(.NCH(NCH), .CW(CW), .LAT(3)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int me[NCH], mp[NCH], mw[NCH];
  bit [NCH-1:0] m_irq, m_dst;

  function automatic int mpick();
    for (int i = 0; i < NCH; i++)
      if (me[i] != 0 && mp[i] > 0 && mw[i] == 0) return i;
    return -1;
  endfunction

  function automatic int mload(int i);
    int c = int'(blk_count[CW*i +: CW]);
    return (c == 0) ? (1 << CW) : c;
  endfunction

  always @(posedge clk) begin : model
    int g;
    int oe[NCH];
    int op[NCH];
    int md;
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin me[i] = 0; mp[i] = 0; mw[i] = 0; end
      m_irq = '0; m_dst = '0;
    end else begin
      g = mpick();
      for (int i = 0; i < NCH; i++) begin oe[i] = me[i]; op[i] = mp[i]; end
      m_irq = '0; m_dst = '0;
      for (int i = 0; i < NCH; i++) if (mw[i] > 0) mw[i]--;
      if (unit_done && g >= 0) begin
        mp[g]--;
        if (mp[g] == 0) begin
          if (!repeat_en[g] || trig_mode[2*g +: 2] == 2'd0) me[g] = 0;
          m_irq[g] = irq_en[g];
          m_dst[g] = reload_en[g];
        end
      end
      for (int i = 0; i < NCH; i++) begin
        md = int'(trig_mode[2*i +: 2]);
        if (en_set[i] && oe[i] == 0) begin
          me[i] = 1;
          if (md == 0) begin mp[i] = mload(i); mw[i] = 3; end
        end else if (oe[i] != 0 && op[i] == 0 &&
                     ((md == 1 && hblank) || (md == 2 && vblank) ||
                      (md == 3 && spec_req[i] && (i == 1 || i == 2)))) begin
          mp[i] = mload(i); mw[i] = 3;
        end
      end
    end
  end

  always @(negedge clk) begin : compare
    int g;
    int st;
    int en;
    g = mpick();
    st = 0; en = 0;
    for (int i = 0; i < NCH; i++) begin
      if (me[i] != 0 && mp[i] > 0) st = 1;
      if (me[i] != 0) en |= (1 << i);
    end
    cmp("R5 grant_valid", int'(grant_valid), int'(g >= 0));
    if (g >= 0) cmp("R5 grant_id", int'(grant_id), g);
    cmp("R10 cpu_stall", int'(cpu_stall), st);
    cmp("R7 ch_enabled", int'(ch_enabled), en);
    cmp("R9 irq", int'(irq), int'(m_irq));
    cmp("R8 dst_restore", int'(dst_restore), int'(m_dst));
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int n;
    tick(3);
    rst_n = 1;
    tick();
    // R1 reset state
    cmp("R1 grant_valid", int'(grant_valid), 0);
    cmp("R1 cpu_stall", int'(cpu_stall), 0);
    cmp("R1 ch_enabled", int'(ch_enabled), 0);
    cmp("R1 irq", int'(irq), 0);

    // R2 latency, R8/R9 end pulses on channel 2
    trig_mode[5:4] = 2'd0; blk_count[11:8] = 4'd2; irq_en[2] = 1; reload_en[2] = 1;
    en_set[2] = 1;
    tick(); en_set = '0;
    cmp("R2 no grant edge1", int'(grant_valid), 0);
    tick(); cmp("R2 no grant edge2", int'(grant_valid), 0);
    tick(); cmp("R2 no grant edge3", int'(grant_valid), 0);
    tick(); cmp("R2 granted", int'(grant_valid && grant_id == 2), 1);
    unit_done = 1;
    tick(2);
    cmp("R9 irq ch2", int'(irq[2]), 1);
    cmp("R8 restore ch2", int'(dst_restore[2]), 1);
    cmp("R7 imm disables", int'(ch_enabled[2]), 0);
    unit_done = 0;

    // R2/R6 zero length means 2^CW units
    trig_mode[3:2] = 2'd0; blk_count[7:4] = 4'd0; en_set[1] = 1;
    tick(); en_set = '0;
    tick(3);
    unit_done = 1;
    n = 0;
    for (int k = 0; k < 30; k++) begin
      if (grant_valid && grant_id == 1) n++;
      tick();
    end
    cmp("R6 zero-length units", n, 1 << CW);
    unit_done = 0;

    // R3 hblank arming, R5 preemption, R7 repeat
    trig_mode[1:0] = 2'd1; repeat_en[0] = 1; blk_count[3:0] = 4'd2;
    trig_mode[7:6] = 2'd0; blk_count[15:12] = 4'd10;
    en_set = 4'b1001;
    tick(); en_set = '0;
    tick(3);
    unit_done = 1;
    tick(2);
    hblank = 1;
    tick(); hblank = 0;
    cmp("R5 ch3 before arm", int'(grant_valid && grant_id == 3), 1);
    tick(2);
    cmp("R5 ch3 in latency", int'(grant_valid && grant_id == 3), 1);
    tick();
    cmp("R5 preempted by ch0", int'(grant_valid && grant_id == 0), 1);
    tick(2);
    cmp("R7 repeat keeps ch0", int'(ch_enabled[0]), 1);
    cmp("R5 back to ch3", int'(grant_valid && grant_id == 3), 1);
    tick(6);
    cmp("R7 after both blocks", int'(ch_enabled), 1);
    unit_done = 0;
    vblank = 1;
    tick(); vblank = 0;
    tick(5);
    cmp("R3 vblank ignored by hblank ch", int'(cpu_stall), 0);
    hblank = 1;
    tick(); hblank = 0;
    tick(3);
    cmp("R3 repeat re-armed", int'(grant_valid && grant_id == 0), 1);
    en_set[0] = 1; hblank = 1;
    tick(); en_set = '0; hblank = 0;
    cmp("R11 no latency reload", int'(grant_valid && grant_id == 0), 1);
    unit_done = 1;
    n = 0;
    for (int k = 0; k < 10; k++) begin
      if (grant_valid && grant_id == 0) n++;
      tick();
    end
    cmp("R11 R3 count not reloaded", n, 2);
    unit_done = 0;

    // R4 special requests
    rst_n = 0; repeat_en = '0;
    tick(2); rst_n = 1;
    trig_mode = 8'hFF; blk_count = 16'h1111;
    en_set = 4'b1111;
    tick(); en_set = '0; spec_req = 4'b1111;
    tick(); spec_req = '0;
    tick(3);
    cmp("R4 ch1 armed ch0 skipped", int'(grant_valid && grant_id == 1), 1);
    unit_done = 1;
    tick();
    cmp("R4 ch2 armed", int'(grant_valid && grant_id == 2), 1);
    tick();
    cmp("R4 ch3 never granted", int'(grant_valid), 0);
    cmp("R4 ch0 ch3 stay enabled", int'(ch_enabled), 9);
    unit_done = 0;

    // mixed random traffic against the model
    rst_n = 0;
    tick(2); rst_n = 1;
    trig_mode = {2'd0, 2'd3, 2'd2, 2'd1};
    repeat_en = 4'b0111; irq_en = 4'b1010; reload_en = 4'b0101;
    blk_count = {4'd4, 4'd5, 4'd2, 4'd3};
    for (int k = 0; k < 3000; k++) begin
      en_set    = ($urandom % 16 == 0) ? 4'($urandom) : '0;
      hblank    = ($urandom % 12 == 0);
      vblank    = ($urandom % 25 == 0);
      spec_req  = ($urandom % 8 == 0) ? 4'($urandom) : '0;
      unit_done = ($urandom % 3 != 0);
      if (k % 500 == 250) repeat_en = 4'($urandom);
      tick();
    end
    en_set = '0; hblank = 0; vblank = 0; spec_req = '0; unit_done = 0;
    tick(2);
    summary();
  end
endmodule